// File: doc/BRIEF.md
# Read Eye Centering Controller

This block trains the read capture delay of every data lane of a DRAM interface. On a start pulse it writes the mode register that switches the DRAM into register-pattern access, so reads return a fixed pattern instead of array contents. It then steps a shared capture delay from the smallest tap to the largest. At every tap it issues a fixed number of reads, one at a time, and compares each lane's captured byte against the expected pattern.

Each lane keeps the longest contiguous run of passing taps. When the sweep ends, every lane is given the tap halfway through its best run. A lane that never passed is flagged and left at the reset tap. The controller then writes the mode register again to leave pattern access, and only then raises done. A later start pulse re-runs the whole sweep without any other set-up, which allows periodic recentering.

Top module: `rd_eye_center`

## Requirements
- R1: During reset and after it, busy, done, cmd_req and all lane_fail bits are 0, and every lane tap equals DLY_RST.
- R2: The first command after a start pulse in the idle or done state is a mode write: cmd_op=2'b01, cmd_mr_idx=3 and cmd_mpr=1, which sets bit 2 of mode register 3. A read is cmd_op=2'b10.
- R3: The sweep visits taps 0 to TAPS-1 in ascending order and issues READS reads per tap. Every lane's tap output equals the current sweep tap while a read is issued, and a new read is issued only after the response to the previous one (rd_valid) has arrived.
- R4: A tap passes for lane i only if every response at that tap has rd_data[i*W +: W] equal to PAT. A single mismatching read fails the tap.
- R5: A lane with passing taps ends at floor((first+last)/2), where first and last bound its longest contiguous passing run. If two runs are equally long, the run with the lower taps is used.
- R6: A lane with no passing tap ends with its lane_fail bit at 1 and its tap at DLY_RST.
- R7: After the sweep, a mode write with cmd_mr_idx=3 and cmd_mpr=0 is issued, and done rises in the cycle after it.
- R8: While done is high and start is low, done and all taps hold their values. rd_valid is ignored outside the wait for a read response.
- R9: A start pulse while a sweep is running has no effect: the run issues exactly TAPS*READS reads and ends with the normal results.
- R10: A start pulse while done is high clears done in the next cycle, raises busy and clears the previous lane_fail flags. It runs a fresh sweep whose results depend only on the new responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Pulse that starts, or re-runs, a training sweep |
| cmd_req | output | 1 | Command issue strobe, one cycle per command |
| cmd_op | output | 2 | 2'b01 mode-register write, 2'b10 read |
| cmd_mr_idx | output | 3 | Mode-register index for a mode write (3), otherwise 0 |
| cmd_mpr | output | 1 | Value written to bit 2 of mode register 3 |
| rd_valid | input | 1 | Captured read data is valid |
| rd_data | input | LANES*W | Captured data, lane i at bits i*W +: W |
| dly_tap | output | LANES*TAP_W | Read capture delay per lane, lane i at bits i*TAP_W +: TAP_W |
| lane_fail | output | LANES | Lane found no passing tap in the last sweep |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Last sweep finished and pattern access has been switched off |

## Verification
Every cycle, the assertions check the command order: pattern access is switched on at the start of busy, only one read is outstanding at a time, done follows the switch-off write, and done holds. They also check the sweep order: the tap only steps by one or returns to zero, and every lane's tap equals the sweep tap during a read. Per lane, they check that a failed lane sits at the reset tap and that a committed tap lies inside the recorded window. Whether the chosen window is really the longest, that ties pick the lower run, that a single bad read fails a tap, and that a re-run forgets the earlier results can only be shown by the bench. The bench sweeps every single-window eye for one lane and scrambled multi-window eyes for the other, with varying response latency.

// File: rtl/rdc_pkg.sv
package rdc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MPR_ON,
    ST_RD_ISSUE,
    ST_RD_WAIT,
    ST_TAP_EVAL,
    ST_CENTER,
    ST_MPR_OFF,
    ST_FIN
  } rdc_state_e;

  localparam logic [1:0] OP_NONE = 2'b00;
  localparam logic [1:0] OP_MODE = 2'b01;
  localparam logic [1:0] OP_READ = 2'b10;

  // mode register holding the pattern-access enable (bit 2)
  localparam logic [2:0] MPR_MR_IDX = 3'd3;

endpackage

// File: rtl/rdc_lane.sv
module rdc_lane #(
  parameter int          W       = 8,
  parameter int          TAPS    = 16,
  parameter int          TAP_W   = 4,
  parameter int          DLY_RST = 8,
  parameter logic [W-1:0] PAT    = 8'hA5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load_en,
  input  logic [TAP_W-1:0] load_tap,
  input  logic             rd_fire,
  input  logic [W-1:0]     rd_data,
  input  logic             tap_close,
  input  logic [TAP_W-1:0] cur_tap,
  input  logic             commit,
  output logic [TAP_W-1:0] dly,
  output logic             fail
);

  localparam int LEN_W = TAP_W + 1;

  logic             tap_ok_q, tap_ok_d;
  logic             in_run_q, in_run_d;
  logic [TAP_W-1:0] cur_start_q, cur_start_d;
  logic [LEN_W-1:0] cur_len_q, cur_len_d;
  logic [TAP_W-1:0] best_first_q, best_first_d;
  logic [TAP_W-1:0] best_last_q, best_last_d;
  logic [LEN_W-1:0] best_len_q, best_len_d;
  logic [TAP_W-1:0] dly_d;
  logic             fail_d;
  logic [LEN_W-1:0] run_len;
  logic [TAP_W-1:0] run_start;
  logic [LEN_W-1:0] mid_sum;

  assign mid_sum = ({1'b0, best_first_q} + {1'b0, best_last_q}) >> 1;

  always_comb begin
    tap_ok_d     = tap_ok_q;
    in_run_d     = in_run_q;
    cur_start_d  = cur_start_q;
    cur_len_d    = cur_len_q;
    best_first_d = best_first_q;
    best_last_d  = best_last_q;
    best_len_d   = best_len_q;
    dly_d        = dly;
    fail_d       = fail;
    run_len      = cur_len_q;
    run_start    = cur_start_q;

    // pass accumulation over the reads of one tap
    if (load_en) begin
      tap_ok_d = 1'b1;
    end else if (rd_fire) begin
      tap_ok_d = tap_ok_q & (rd_data == PAT);
    end

    // window tracking
    if (clear) begin
      in_run_d     = 1'b0;
      cur_start_d  = '0;
      cur_len_d    = '0;
      best_first_d = '0;
      best_last_d  = '0;
      best_len_d   = '0;
    end else if (tap_close) begin
      if (tap_ok_q) begin
        if (in_run_q) begin
          run_len   = cur_len_q + LEN_W'(1);
          run_start = cur_start_q;
        end else begin
          run_len   = LEN_W'(1);
          run_start = cur_tap;
        end
        in_run_d    = 1'b1;
        cur_len_d   = run_len;
        cur_start_d = run_start;
        if (run_len > best_len_q) begin
          best_first_d = run_start;
          best_last_d  = cur_tap;
          best_len_d   = run_len;
        end
      end else begin
        in_run_d = 1'b0;
      end
    end

    // delay output and failure flag
    if (load_en) begin
      dly_d = load_tap;
    end else if (commit) begin
      dly_d = (best_len_q == '0) ? TAP_W'(DLY_RST) : mid_sum[TAP_W-1:0];
    end

    if (clear) begin
      fail_d = 1'b0;
    end else if (commit) begin
      fail_d = (best_len_q == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_ok_q     <= 1'b0;
      in_run_q     <= 1'b0;
      cur_start_q  <= '0;
      cur_len_q    <= '0;
      best_first_q <= '0;
      best_last_q  <= '0;
      best_len_q   <= '0;
      dly          <= TAP_W'(DLY_RST);
      fail         <= 1'b0;
    end else begin
      tap_ok_q     <= tap_ok_d;
      in_run_q     <= in_run_d;
      cur_start_q  <= cur_start_d;
      cur_len_q    <= cur_len_d;
      best_first_q <= best_first_d;
      best_last_q  <= best_last_d;
      best_len_q   <= best_len_d;
      dly          <= dly_d;
      fail         <= fail_d;
    end
  end

  // R6: a failed lane sits at the reset tap
  a_r6_fail_at_reset_tap: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (dly == TAP_W'(DLY_RST)));

  // R5: the committed tap lies inside the recorded window
  a_r5_center_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (best_len_q != '0)) |=>
      ((dly >= $past(best_first_q)) && (dly <= $past(best_last_q))));

  // R4: one mismatching read fails the tap
  a_r4_mismatch_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && (rd_data != PAT) && !load_en) |=> !tap_ok_q);

endmodule

// File: rtl/rdc_seq.sv
module rdc_seq
  import rdc_pkg::*;
#(
  parameter int TAPS  = 16,
  parameter int TAP_W = 4,
  parameter int READS = 2,
  parameter int RD_W  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rd_valid,
  output logic             cmd_req,
  output logic [1:0]       cmd_op,
  output logic             cmd_mpr,
  output logic             clear,
  output logic             load_en,
  output logic [TAP_W-1:0] load_tap,
  output logic             rd_fire,
  output logic             tap_close,
  output logic [TAP_W-1:0] cur_tap,
  output logic             commit,
  output logic             busy,
  output logic             done
);

  localparam logic [TAP_W-1:0] TAP_LAST = TAP_W'(TAPS - 1);
  localparam logic [RD_W-1:0]  RD_LAST  = RD_W'(READS - 1);

  rdc_state_e       state_q, state_d;
  logic [TAP_W-1:0] tap_q, tap_d;
  logic [RD_W-1:0]  rcnt_q, rcnt_d;

  always_comb begin
    state_d   = state_q;
    tap_d     = tap_q;
    rcnt_d    = rcnt_q;
    cmd_req   = 1'b0;
    cmd_op    = OP_NONE;
    cmd_mpr   = 1'b0;
    clear     = 1'b0;
    load_en   = 1'b0;
    load_tap  = tap_q;
    rd_fire   = 1'b0;
    tap_close = 1'b0;
    commit    = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_FIN: begin
        if (start) begin
          clear    = 1'b1;
          load_en  = 1'b1;
          load_tap = '0;
          tap_d    = '0;
          rcnt_d   = '0;
          state_d  = ST_MPR_ON;
        end
      end
      ST_MPR_ON: begin
        cmd_req = 1'b1;
        cmd_op  = OP_MODE;
        cmd_mpr = 1'b1;
        state_d = ST_RD_ISSUE;
      end
      ST_RD_ISSUE: begin
        cmd_req = 1'b1;
        cmd_op  = OP_READ;
        state_d = ST_RD_WAIT;
      end
      ST_RD_WAIT: begin
        if (rd_valid) begin
          rd_fire = 1'b1;
          if (rcnt_q == RD_LAST) begin
            rcnt_d  = '0;
            state_d = ST_TAP_EVAL;
          end else begin
            rcnt_d  = rcnt_q + RD_W'(1);
            state_d = ST_RD_ISSUE;
          end
        end
      end
      ST_TAP_EVAL: begin
        tap_close = 1'b1;
        if (tap_q == TAP_LAST) begin
          state_d = ST_CENTER;
        end else begin
          tap_d    = tap_q + TAP_W'(1);
          load_en  = 1'b1;
          load_tap = tap_q + TAP_W'(1);
          state_d  = ST_RD_ISSUE;
        end
      end
      ST_CENTER: begin
        commit  = 1'b1;
        state_d = ST_MPR_OFF;
      end
      ST_MPR_OFF: begin
        cmd_req = 1'b1;
        cmd_op  = OP_MODE;
        cmd_mpr = 1'b0;
        state_d = ST_FIN;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tap_q   <= '0;
      rcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      tap_q   <= tap_d;
      rcnt_q  <= rcnt_d;
    end
  end

  assign cur_tap = tap_q;
  assign busy    = (state_q != ST_IDLE) && (state_q != ST_FIN);
  assign done    = (state_q == ST_FIN);

  // R2: a sweep opens with the pattern-access enable write
  a_r2_first_cmd_mpr_on: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cmd_req && (cmd_op == OP_MODE) && cmd_mpr));

  // R3: one read outstanding at a time
  a_r3_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && (cmd_op == OP_READ)) |=> !cmd_req);

  // R3: the sweep tap steps by one or restarts at zero
  a_r3_tap_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tap_q) |-> ((tap_q == $past(tap_q) + TAP_W'(1)) || (tap_q == '0)));

  // R7: done follows the pattern-access disable write
  a_r7_done_after_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(cmd_req && (cmd_op == OP_MODE) && !cmd_mpr));

  // R8: done holds without a start pulse
  a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R9: start during a sweep keeps the sweep running
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && (state_q != ST_MPR_OFF)) |=> busy);

endmodule

// File: rtl/rd_eye_center.sv
module rd_eye_center
  import rdc_pkg::*;
#(
  parameter int           LANES   = 2,
  parameter int           W       = 8,
  parameter int           TAPS    = 16,
  parameter int           READS   = 2,
  parameter int           DLY_RST = 8,
  parameter logic [W-1:0] PAT     = 8'hA5,
  localparam int          TAP_W   = (TAPS > 1) ? $clog2(TAPS) : 1,
  localparam int          RD_W    = (READS > 1) ? $clog2(READS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  output logic                   cmd_req,
  output logic [1:0]             cmd_op,
  output logic [2:0]             cmd_mr_idx,
  output logic                   cmd_mpr,
  input  logic                   rd_valid,
  input  logic [LANES*W-1:0]     rd_data,
  output logic [LANES*TAP_W-1:0] dly_tap,
  output logic [LANES-1:0]       lane_fail,
  output logic                   busy,
  output logic                   done
);

  logic [1:0]       rst_sync;
  logic             rst_ni;
  logic             clear, load_en, rd_fire, tap_close, commit;
  logic [TAP_W-1:0] load_tap, cur_tap;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_ni = rst_sync[1];

  rdc_seq #(
    .TAPS  (TAPS),
    .TAP_W (TAP_W),
    .READS (READS),
    .RD_W  (RD_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_ni),
    .start     (start),
    .rd_valid  (rd_valid),
    .cmd_req   (cmd_req),
    .cmd_op    (cmd_op),
    .cmd_mpr   (cmd_mpr),
    .clear     (clear),
    .load_en   (load_en),
    .load_tap  (load_tap),
    .rd_fire   (rd_fire),
    .tap_close (tap_close),
    .cur_tap   (cur_tap),
    .commit    (commit),
    .busy      (busy),
    .done      (done)
  );

  assign cmd_mr_idx = (cmd_op == OP_MODE) ? MPR_MR_IDX : 3'd0;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    rdc_lane #(
      .W       (W),
      .TAPS    (TAPS),
      .TAP_W   (TAP_W),
      .DLY_RST (DLY_RST),
      .PAT     (PAT)
    ) u_lane (
      .clk       (clk),
      .rst_n     (rst_ni),
      .clear     (clear),
      .load_en   (load_en),
      .load_tap  (load_tap),
      .rd_fire   (rd_fire),
      .rd_data   (rd_data[l*W +: W]),
      .tap_close (tap_close),
      .cur_tap   (cur_tap),
      .commit    (commit),
      .dly       (dly_tap[l*TAP_W +: TAP_W]),
      .fail      (lane_fail[l])
    );

    // R3: every lane captures at the sweep tap while a read goes out
    a_r3_lane_at_sweep_tap: assert property (@(posedge clk) disable iff (!rst_ni)
      (cmd_req && (cmd_op == OP_READ)) |-> (dly_tap[l*TAP_W +: TAP_W] == cur_tap));
  end

  // R1: no command outside a sweep
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy |-> !cmd_req);

endmodule

// File: tb/rd_eye_center_test.sv
`timescale 1ns/1ps
module rd_eye_center_test;

  localparam int          LANES = 2;
  localparam int          W     = 8;
  localparam int          TAPS  = 16;
  localparam int          NR    = 2;
  localparam int          DRST  = 8;
  localparam int          TW    = 4;
  localparam logic [7:0]  PAT   = 8'hA5;

  logic clk = 1'b0;
  logic rst_n, start, rd_valid;
  logic [LANES*W-1:0]  rd_data;
  logic                cmd_req, cmd_mpr, busy, done;
  logic [1:0]          cmd_op;
  logic [2:0]          cmd_mr_idx;
  logic [LANES*TW-1:0] dly_tap;
  logic [LANES-1:0]    lane_fail;

  rd_eye_center #(
    .LANES(LANES), .W(W), .TAPS(TAPS), .READS(NR), .DLY_RST(DRST), .PAT(PAT)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cmd_req(cmd_req), .cmd_op(cmd_op), .cmd_mr_idx(cmd_mr_idx), .cmd_mpr(cmd_mpr),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .dly_tap(dly_tap), .lane_fail(lane_fail), .busy(busy), .done(done)
  );

  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;

  // response model and command monitor state
  logic [15:0] mask0, mask1;
  int  ctap = -1;
  int  lat = 1;
  bit  stray = 1'b0;
  int  pend = 0;
  logic [LANES*W-1:0] resp_data;
  int  rd_seen, nmode, off_cyc, rise_cyc, cyc = 0;
  bit  first_ok, off_ok, tap_seq_bad;
  logic done_prev = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic void calc(input logic [15:0] m, output int tap, output bit fl);
    int bl = 0, bf = 0, bla = 0, cl = 0, cs = 0;
    for (int t = 0; t < TAPS; t++) begin
      if (m[t]) begin
        if (cl == 0) cs = t;
        cl++;
        if (cl > bl) begin bl = cl; bf = cs; bla = t; end
      end else begin
        cl = 0;
      end
    end
    if (bl == 0) begin tap = DRST; fl = 1'b1; end
    else begin tap = (bf + bla) / 2; fl = 1'b0; end
  endfunction

  always @(negedge clk) begin
    cyc++;
    rd_valid = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin rd_valid = 1'b1; rd_data = resp_data; end
    end else if (stray) begin
      rd_valid = 1'b1;
      rd_data  = ~{PAT, PAT};
    end
    if (rst_n && cmd_req) begin
      if (cmd_op == 2'b10) begin
        for (int l = 0; l < LANES; l++) begin
          int tp;
          bit pass;
          tp = int'(dly_tap[l*TW +: TW]);
          if (tp != rd_seen / NR) tap_seq_bad = 1'b1;
          pass = (l == 0) ? mask0[tp] : mask1[tp];
          if (l == 0 && rd_seen == ctap * NR + NR - 1) pass = 1'b0;
          resp_data[l*W +: W] = pass ? PAT : (PAT ^ (8'h01 << l));
        end
        pend = lat;
        rd_seen++;
      end else begin
        if (nmode == 0) first_ok = (cmd_op == 2'b01) && (cmd_mr_idx == 3'd3) && cmd_mpr;
        nmode++;
        if (!cmd_mpr) begin off_cyc = cyc; off_ok = (cmd_mr_idx == 3'd3) && (cmd_op == 2'b01); end
      end
    end
    if (done && !done_prev) rise_cyc = cyc;
    done_prev = done;
  end

  task automatic run_case(input logic [15:0] m0, input logic [15:0] m1,
                          input int ct, input int l_lat, input bit mid_start,
                          input string tag0, input string tag1);
    int n;
    int et0, et1;
    bit ef0, ef1;
    logic [15:0] eff0;
    mask0 = m0; mask1 = m1; ctap = ct; lat = l_lat;
    rd_seen = 0; nmode = 0; first_ok = 0; off_ok = 0; tap_seq_bad = 0;
    off_cyc = -100; rise_cyc = -200;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    // R10: a start clears done and raises busy in the next cycle
    check(!done && busy, "R10", {done, busy}, 1);
    n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
      start = (mid_start && n == 40);
    end
    start = 1'b0;
    @(negedge clk);
    check(n < 3000, "R3 sweep timeout", n, 3000);
    check(first_ok, "R2", first_ok, 1);
    check(rd_seen == TAPS * NR && !tap_seq_bad,
          mid_start ? "R9" : "R3", rd_seen, TAPS * NR);
    check(off_ok && rise_cyc == off_cyc + 1, "R7", rise_cyc, off_cyc + 1);
    eff0 = m0;
    if (ct >= 0) eff0[ct] = 1'b0;
    calc(eff0, et0, ef0);
    calc(m1, et1, ef1);
    check(int'(dly_tap[0 +: TW]) == et0, tag0, int'(dly_tap[0 +: TW]), et0);
    check(lane_fail[0] == ef0, ef0 ? "R6" : tag0, lane_fail[0], ef0);
    check(int'(dly_tap[TW +: TW]) == et1, tag1, int'(dly_tap[TW +: TW]), et1);
    check(lane_fail[1] == ef1, ef1 ? "R6" : tag1, lane_fail[1], ef1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_report();
  end

  initial begin
    logic [LANES*TW-1:0] hold_tap;
    int hold_seen;
    rst_n = 1'b0; start = 1'b0; rd_valid = 1'b0; rd_data = '0;
    mask0 = '0; mask1 = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !done && !cmd_req && lane_fail == '0, "R1", {busy, done, cmd_req}, 0);
    check(dly_tap == {LANES{TW'(DRST)}}, "R1", dly_tap, {LANES{TW'(DRST)}});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !done && !cmd_req && lane_fail == '0, "R1", {busy, done, cmd_req}, 0);
    check(dly_tap == {LANES{TW'(DRST)}}, "R1", dly_tap, {LANES{TW'(DRST)}});

    // full eye on both lanes
    run_case(16'hFFFF, 16'hFFFF, -1, 1, 1'b0, "R5", "R5");
    // lane 1 without any passing tap
    run_case(16'h0FF0, 16'h0000, -1, 2, 1'b0, "R5", "R6");
    // R10: the next run clears the old fail flag
    run_case(16'h0000, 16'h00F8, -1, 1, 1'b0, "R6", "R10");
    // equal-length windows: the lower run wins (R5)
    run_case(16'hF0F0, 16'h0F0F, -1, 1, 1'b0, "R5", "R5");
    // R4: one bad read at tap 7 of lane 0 splits the eye
    run_case(16'hFFFF, 16'h7FFE, 7, 2, 1'b0, "R4", "R5");
    run_case(16'h01FC, 16'h3FF0, 3, 3, 1'b0, "R4", "R5");
    // R9: a start pulse in mid sweep changes nothing
    run_case(16'h3FC0, 16'h03F0, -1, 1, 1'b1, "R9", "R9");

    // R8: stray responses while done is high are ignored
    hold_tap = dly_tap;
    hold_seen = rd_seen;
    stray = 1'b1;
    repeat (3) @(negedge clk);
    stray = 1'b0;
    repeat (2) @(negedge clk);
    check(done && !busy, "R8", {done, busy}, 2);
    check(dly_tap == hold_tap && rd_seen == hold_seen, "R8", dly_tap, hold_tap);

    // every single-window eye on lane 0, scrambled eyes on lane 1
    for (int a = 0; a < TAPS; a++) begin
      for (int b = a; b < TAPS; b++) begin
        logic [15:0] m0, m1;
        m0 = 16'(((32'h1 << (b + 1)) - 1) & ~((32'h1 << a) - 1));
        m1 = 16'((a * 40503) ^ (b * 7919) ^ 16'h3C96);
        run_case(m0, m1, -1, 1 + (a + b) % 3, 1'b0, "R5", "R5");
      end
    end

    finish_report();
  end

endmodule